// File: doc/BRIEF.md
# Bus-Matching FIFO Width Converter

This block is a single first-in first-out buffer whose storage is built from 36-bit words. The width of each port is chosen at master reset from three setup inputs. The choices are 36, 18 or 9 bits, and at least one of the two ports is always 36 bits. On a narrow write port, successive units are packed into one storage word starting at the least significant end. On a narrow read port, the head word is handed out one unit at a time in the same little-endian order. Narrow data always travels on the low bits of the 36-bit data buses.

Each flag counts in the units of its own port. The full flag stays set until a whole storage word has been freed. On a 9-bit read port that takes four reads. The output-valid flag rises only when a complete storage word exists. On an 18-bit write port that takes two writes. The read port works in show-ahead fashion: while `rd_valid` is high, `rd_data` already shows the next unit, and raising `rd_en` consumes it at the clock edge.

The width configuration is held by a small state machine. While reset is asserted, it samples the setup inputs on every clock and moves to one of five states. After reset it keeps its state until the next master reset. The states and the setup codes that select them are:

- `MODE_W36_R36`: `cfg_convert`=0, with any value on the other two inputs.
- `MODE_W36_R18`: `cfg_convert`=1, `cfg_narrow_wr`=0, `cfg_narrow_9`=0.
- `MODE_W36_R9`: `cfg_convert`=1, `cfg_narrow_wr`=0, `cfg_narrow_9`=1.
- `MODE_W18_R36`: `cfg_convert`=1, `cfg_narrow_wr`=1, `cfg_narrow_9`=0.
- `MODE_W9_R36`: `cfg_convert`=1, `cfg_narrow_wr`=1, `cfg_narrow_9`=1.

The only transition is "reset sample", taken on each clock while `rst_n` is low. There is no transition while `rst_n` is high.

Top module: `busmatch_fifo`

## Requirements
- R1: With `cfg_convert`=0 at reset, both ports are 36 bits wide whatever the other two setup inputs are. Each write is read back as one identical 36-bit word.
- R2: Setup code convert=1, narrow_wr=0, narrow_9=0 gives 36-bit writes and 18-bit reads. A word is read as bits [17:0] first, then bits [35:18], each placed on `rd_data[17:0]` with `rd_data[35:18]` zero.
- R3: Setup code convert=1, narrow_wr=0, narrow_9=1 gives 36-bit writes and 9-bit reads. Read k (k=0..3) returns word bits [9k+8:9k] on `rd_data[8:0]`, with the upper bits zero.
- R4: Setup code convert=1, narrow_wr=1, narrow_9=0 gives 18-bit writes from `wr_data[17:0]` and 36-bit reads. The first write fills bits [17:0] and the second fills bits [35:18]. `rd_valid` stays low until the second write, and the bits of `wr_data` above bit 17 are ignored.
- R5: Setup code convert=1, narrow_wr=1, narrow_9=1 gives 9-bit writes from `wr_data[8:0]` and 36-bit reads. Write k (k=0..3) fills bits [9k+8:9k], and a word with fewer than four units is not visible to the read port.
- R6: `wr_full` is high once DEPTH storage words are held. A write while `wr_full` is high is ignored and alters no stored data.
- R7: The full flag counts in write units. With 36-bit writes and 9-bit reads, a full buffer keeps `wr_full` high after three reads and drops it after the fourth.
- R8: `rd_valid` is low after reset and whenever no complete word is stored. A read while `rd_valid` is low is ignored and does not advance the narrow read position.
- R9: The setup inputs are sampled only while `rst_n` is low. Changing them after reset has no effect on the widths.
- R10: Master reset empties the buffer and clears the packing and unpacking positions. A partially packed word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous master reset, active low; the setup inputs are sampled while it is low |
| cfg_convert | input | 1 | Setup: 0 selects 36/36, 1 enables width conversion |
| cfg_narrow_wr | input | 1 | Setup: 1 makes the write port the narrow side, 0 the read port |
| cfg_narrow_9 | input | 1 | Setup: narrow side width, 0 selects 18 bits, 1 selects 9 bits |
| wr_en | input | 1 | Write one unit of the write width |
| wr_data | input | 36 | Write data; narrow units on the low bits |
| wr_full | output | 1 | No room for another write unit |
| rd_en | input | 1 | Consume the unit shown on rd_data |
| rd_data | output | 36 | Show-ahead read data; narrow units on the low bits, upper bits zero |
| rd_valid | output | 1 | rd_data holds a valid unit |

## Verification
A write or read takes effect at the clock edge where its enable is sampled high. `wr_full` and `rd_valid` follow one edge later, so they are sampled at the falling edge right after that edge. `rd_data` is show-ahead, so the unit to be consumed is compared at the falling edge before the read edge. A completed narrow write becomes visible on `rd_data` and `rd_valid` at the falling edge after the final unit's edge. The bench drives every input at falling edges and samples every output at the next falling edge, so each result is read exactly one edge after the stimulus that causes it.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        MODE_W36_R36,
        MODE_W36_R18,
        MODE_W36_R9,
        MODE_W18_R36,
        MODE_W9_R36
    } bm_mode_e;

    typedef enum logic [1:0] {
        UW_36,
        UW_18,
        UW_9
    } unit_w_e;

    function automatic bm_mode_e decode_mode(logic conv, logic narrow_wr, logic narrow_9);
        bm_mode_e m;
        if (!conv) begin
            m = MODE_W36_R36;
        end else begin
            unique case ({narrow_wr, narrow_9})
                2'b00:   m = MODE_W36_R18;
                2'b01:   m = MODE_W36_R9;
                2'b10:   m = MODE_W18_R36;
                default: m = MODE_W9_R36;
            endcase
        end
        return m;
    endfunction

    function automatic logic [1:0] last_unit(unit_w_e u);
        logic [1:0] r;
        unique case (u)
            UW_18:   r = 2'd1;
            UW_9:    r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/busmatch_mode_reg.sv
module busmatch_mode_reg
    import busmatch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_convert,
    input  logic     cfg_narrow_wr,
    input  logic     cfg_narrow_9,
    output bm_mode_e mode_q,
    output unit_w_e  wr_unit,
    output unit_w_e  rd_unit
);

    bm_mode_e mode_d;

    assign mode_d = decode_mode(cfg_convert, cfg_narrow_wr, cfg_narrow_9);

    // state register: reset-sample transition only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_d;
        end
    end

    // outputs: per-port unit width
    always_comb begin
        wr_unit = UW_36;
        rd_unit = UW_36;
        unique case (mode_q)
            MODE_W36_R36: begin wr_unit = UW_36; rd_unit = UW_36; end
            MODE_W36_R18: begin wr_unit = UW_36; rd_unit = UW_18; end
            MODE_W36_R9:  begin wr_unit = UW_36; rd_unit = UW_9;  end
            MODE_W18_R36: begin wr_unit = UW_18; rd_unit = UW_36; end
            MODE_W9_R36:  begin wr_unit = UW_9;  rd_unit = UW_36; end
            default:      begin wr_unit = UW_36; rd_unit = UW_36; end
        endcase
    end

endmodule

// File: rtl/busmatch_pack.sv
module busmatch_pack
    import busmatch_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  unit_w_e       wr_unit,
    input  logic          wr_fire,
    input  logic [DW-1:0] wr_data,
    output logic          commit,
    output logic [DW-1:0] commit_word
);

    localparam int LW = DW / LANES;

    logic [1:0]    idx_q;
    logic [DW-1:0] stage_q;
    logic [DW-1:0] merged;

    always_comb begin
        merged = stage_q;
        for (int g = 0; g < LANES; g++) begin
            unique case (wr_unit)
                UW_36: merged[g*LW +: LW] = wr_data[g*LW +: LW];
                UW_18: begin
                    if (idx_q == 2'(g >> 1)) begin
                        merged[g*LW +: LW] = wr_data[(g % 2)*LW +: LW];
                    end
                end
                UW_9: begin
                    if (idx_q == 2'(g)) begin
                        merged[g*LW +: LW] = wr_data[LW-1:0];
                    end
                end
                default: merged[g*LW +: LW] = stage_q[g*LW +: LW];
            endcase
        end
    end

    assign commit      = wr_fire && (idx_q == last_unit(wr_unit));
    assign commit_word = merged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            stage_q <= '0;
        end else if (wr_fire) begin
            stage_q <= merged;
            idx_q   <= commit ? 2'd0 : idx_q + 2'd1;
        end
    end

endmodule

// File: rtl/busmatch_store.sv
module busmatch_store #(
    parameter int DW    = 36,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_word,
    input  logic          pop,
    output logic [DW-1:0] head_word,
    output logic          full,
    output logic          empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;

    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign head_word = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/busmatch_unpack.sv
module busmatch_unpack
    import busmatch_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  unit_w_e       rd_unit,
    input  logic          rd_fire,
    input  logic [DW-1:0] head_word,
    output logic          pop,
    output logic [DW-1:0] rd_data
);

    localparam int LW = DW / LANES;

    logic [1:0] idx_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_unit)
            UW_36: rd_data = head_word;
            UW_18: rd_data[2*LW-1:0] = head_word[(idx_q[0] ? 2*LW : 0) +: 2*LW];
            UW_9:  rd_data[LW-1:0]   = head_word[int'(idx_q)*LW +: LW];
            default: rd_data = head_word;
        endcase
    end

    assign pop = rd_fire && (idx_q == last_unit(rd_unit));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (rd_fire) begin
            idx_q <= pop ? 2'd0 : idx_q + 2'd1;
        end
    end

endmodule

// File: rtl/busmatch_fifo.sv
module busmatch_fifo
    import busmatch_pkg::*;
#(
    parameter int DW    = 36,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_convert,
    input  logic          cfg_narrow_wr,
    input  logic          cfg_narrow_9,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    bm_mode_e      mode_q;
    unit_w_e       wr_unit, rd_unit;
    logic          wr_fire, rd_fire;
    logic          commit, pop;
    logic [DW-1:0] commit_word, head_word;
    logic          st_full, st_empty;

    assign wr_full  = st_full;
    assign rd_valid = !st_empty;
    assign wr_fire  = wr_en && !st_full;
    assign rd_fire  = rd_en && !st_empty;

    busmatch_mode_reg u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_convert   (cfg_convert),
        .cfg_narrow_wr (cfg_narrow_wr),
        .cfg_narrow_9  (cfg_narrow_9),
        .mode_q        (mode_q),
        .wr_unit       (wr_unit),
        .rd_unit       (rd_unit)
    );

    busmatch_pack #(.DW(DW)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_unit     (wr_unit),
        .wr_fire     (wr_fire),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_word (commit_word)
    );

    busmatch_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit),
        .push_word (commit_word),
        .pop       (pop),
        .head_word (head_word),
        .full      (st_full),
        .empty     (st_empty)
    );

    busmatch_unpack #(.DW(DW)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_unit   (rd_unit),
        .rd_fire   (rd_fire),
        .head_word (head_word),
        .pop       (pop),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/busmatch_fifo_chk.sv
module busmatch_fifo_chk
    import busmatch_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     wr_en,
    input logic     rd_en,
    input logic     wr_full,
    input logic     rd_valid,
    input bm_mode_e mode_q
);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && !rd_en) |=> wr_full);

    // R7
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_full) && $past(rst_n)) |-> $past(rd_en));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && $past(rst_n)) |-> $past(wr_en));

    // R8
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !wr_en) |=> !rd_valid);

endmodule

bind busmatch_fifo busmatch_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_full  (wr_full),
    .rd_valid (rd_valid),
    .mode_q   (mode_q)
);

// File: tb/busmatch_fifo_tb.sv
module busmatch_fifo_tb;

    localparam int DW    = 36;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_convert = 1'b0, cfg_narrow_wr = 1'b0, cfg_narrow_9 = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_valid;
    logic [DW-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    busmatch_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_convert   (cfg_convert),
        .cfg_narrow_wr (cfg_narrow_wr),
        .cfg_narrow_9  (cfg_narrow_9),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_full       (wr_full),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic c, input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cfg_convert = c; cfg_narrow_wr = a; cfg_narrow_9 = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_chk(input logic [DW-1:0] exp, input string req);
        check(rd_valid === 1'b1, req, {35'd0, rd_valid}, 36'd1);
        check(rd_data === exp, req, rd_data, exp);
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 1'b0, 1'b0);
        check(rd_valid === 1'b0, "R8 reset valid", {35'd0, rd_valid}, 36'd0);
        check(wr_full === 1'b0, "R8 reset full", {35'd0, wr_full}, 36'd0);
    endtask

    task automatic t_r1_wide();
        do_reset(1'b0, 1'b1, 1'b1);
        push(36'hA_1234_5678);
        push(36'h5_9ABC_DEF0);
        push(36'hF_0F0F_0F0F);
        pop_chk(36'hA_1234_5678, "R1 word0");
        pop_chk(36'h5_9ABC_DEF0, "R1 word1");
        pop_chk(36'hF_0F0F_0F0F, "R1 word2");
        check(rd_valid === 1'b0, "R1 drained", {35'd0, rd_valid}, 36'd0);
    endtask

    task automatic t_r2_read18();
        logic [DW-1:0] w = 36'hB_CDE1_2345;
        do_reset(1'b1, 1'b0, 1'b0);
        push(w);
        pop_chk({18'd0, w[17:0]}, "R2 low half");
        pop_chk({18'd0, w[35:18]}, "R2 high half");
        check(rd_valid === 1'b0, "R2 drained", {35'd0, rd_valid}, 36'd0);
    endtask

    task automatic t_r3_read9();
        logic [DW-1:0] w = 36'h7_6543_21FE;
        do_reset(1'b1, 1'b0, 1'b1);
        push(w);
        pop_chk({27'd0, w[8:0]},   "R3 unit0");
        pop_chk({27'd0, w[17:9]},  "R3 unit1");
        pop_chk({27'd0, w[26:18]}, "R3 unit2");
        pop_chk({27'd0, w[35:27]}, "R3 unit3");
        check(rd_valid === 1'b0, "R3 drained", {35'd0, rd_valid}, 36'd0);
    endtask

    task automatic t_r4_write18();
        do_reset(1'b1, 1'b1, 1'b0);
        push({18'h3FFFF, 18'h1_2345});
        check(rd_valid === 1'b0, "R4 partial hidden", {35'd0, rd_valid}, 36'd0);
        push({18'h2AAAA, 18'h2_BCDE});
        pop_chk({18'h2_BCDE, 18'h1_2345}, "R4 packed");
    endtask

    task automatic t_r5_write9();
        do_reset(1'b1, 1'b1, 1'b1);
        push({27'h7FF_FFFF, 9'h011});
        push({27'h0, 9'h122});
        push({27'h0, 9'h033});
        check(rd_valid === 1'b0, "R5 partial hidden", {35'd0, rd_valid}, 36'd0);
        push({27'h0, 9'h1C4});
        pop_chk({9'h1C4, 9'h033, 9'h122, 9'h011}, "R5 packed");
    endtask

    task automatic t_r6_full();
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) push({4'h9, 32'(i) * 32'h0101_0101});
        check(wr_full === 1'b1, "R6 full set", {35'd0, wr_full}, 36'd1);
        push(36'hD_EADB_EEF0);
        check(wr_full === 1'b1, "R6 still full", {35'd0, wr_full}, 36'd1);
        for (int i = 0; i < DEPTH; i++) pop_chk({4'h9, 32'(i) * 32'h0101_0101}, "R6 data intact");
        check(rd_valid === 1'b0, "R6 overflow dropped", {35'd0, rd_valid}, 36'd0);
    endtask

    task automatic t_r7_full_units();
        do_reset(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < DEPTH; i++) push(36'(i + 1));
        check(wr_full === 1'b1, "R7 full", {35'd0, wr_full}, 36'd1);
        for (int k = 0; k < 3; k++) begin
            rd_en = 1'b1; @(posedge clk); @(negedge clk); rd_en = 1'b0;
            check(wr_full === 1'b1, "R7 full after partial reads", {35'd0, wr_full}, 36'd1);
        end
        rd_en = 1'b1; @(posedge clk); @(negedge clk); rd_en = 1'b0;
        check(wr_full === 1'b0, "R7 released on fourth read", {35'd0, wr_full}, 36'd0);
    endtask

    task automatic t_r8_empty_read();
        logic [DW-1:0] w = 36'h3_1415_9265;
        do_reset(1'b1, 1'b0, 1'b1);
        rd_en = 1'b1; @(posedge clk); @(negedge clk); rd_en = 1'b0;
        check(rd_valid === 1'b0, "R8 empty read ignored", {35'd0, rd_valid}, 36'd0);
        push(w);
        pop_chk({27'd0, w[8:0]}, "R8 position unmoved");
        pop_chk({27'd0, w[17:9]}, "R8 next unit");
    endtask

    task automatic t_r9_pins_late();
        do_reset(1'b1, 1'b1, 1'b0);
        cfg_convert = 1'b0; cfg_narrow_wr = 1'b0; cfg_narrow_9 = 1'b1;
        @(negedge clk);
        push({18'h0, 18'h0_0ABC});
        check(rd_valid === 1'b0, "R9 still 18-bit writes", {35'd0, rd_valid}, 36'd0);
        push({18'h0, 18'h1_1111});
        pop_chk({18'h1_1111, 18'h0_0ABC}, "R9 mode kept");
    endtask

    task automatic t_r10_reset_partial();
        do_reset(1'b1, 1'b1, 1'b1);
        push({27'h0, 9'h1AA});
        push({27'h0, 9'h155});
        do_reset(1'b1, 1'b1, 1'b1);
        check(rd_valid === 1'b0, "R10 valid cleared", {35'd0, rd_valid}, 36'd0);
        push({27'h0, 9'h001});
        push({27'h0, 9'h002});
        push({27'h0, 9'h003});
        push({27'h0, 9'h004});
        pop_chk({9'h004, 9'h003, 9'h002, 9'h001}, "R10 partial discarded");
        check(rd_valid === 1'b0, "R10 single word", {35'd0, rd_valid}, 36'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_r1_wide();
        t_r2_read18();
        t_r3_read9();
        t_r4_write18();
        t_r5_write9();
        t_r6_full();
        t_r7_full_units();
        t_r8_empty_read();
        t_r9_pins_late();
        t_r10_reset_partial();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule